// File: doc/BRIEF.md
# NAND Hamming ECC syndrome corrector

This block judges one flash page read against its stored error-correcting code. For every 256-byte chunk it receives two 24-bit codes: the one computed over the data as it came off the flash, and the one read back from the spare area. It XORs them into a syndrome. It then sorts the outcome into one of four classes: clean, a correctable single data bit, an error in the stored code itself, or an uncorrectable error. For a correctable error it also reports the byte offset within the chunk and a one-hot mask of the bit to flip. The consumer applies the fix to its own buffer.

A page-size select picks 256-byte pages, which use one chunk and the low code bytes 0 to 2. It can instead pick 512-byte pages, which use two independent chunks, with the upper chunk taking code bytes 3 to 5. Each code is packed least significant byte first. Within a chunk code, bits [10:0] hold one 11-bit parity group and bits [21:11] hold its complementary group. A small two-state machine captures the verdict one clock after the input strobe and raises a one-cycle done pulse. It holds every result until the next strobe.

States: `PH_IDLE` (no fresh result) and `PH_REPORT` (result from the strobe of the previous cycle is on the outputs). Transitions: `take` (any state to `PH_REPORT` when `in_valid` is high) and `retire` (any state to `PH_IDLE` when `in_valid` is low).

Top module: `nand_ecc_syndrome`

## Requirements
- R1: A chunk is reported clean (status 2'b00) when its syndrome is zero, when its computed code is all zero, or when its stored code is all zero.
- R2: Otherwise, when exactly one of the 24 syndrome bits is set, the chunk status is 2'b10 (the stored code is wrong and the data is intact).
- R3: Otherwise, the status is 2'b01 (one data bit correctable) when exactly 11 syndrome bits are set and the following value equals 0x7FF: the XOR of the computed code's bits [10:0] and [21:11], XORed with the same value formed from the stored code. For this status the byte offset output is syndrome bits [10:3] and the mask is 1 shifted left by syndrome bits [2:0].
- R4: Every other non-clean syndrome gives status 2'b11 (uncorrectable).
- R5: A chunk's byte offset and mask are both zero whenever its status is not 2'b01.
- R6: The results appear on the clock edge that samples `in_valid` high. `done` is high for exactly the following cycle. All results hold until the next strobe.
- R7: With `wide_page` = 1, bits [47:24] of both code inputs form the upper chunk. That chunk is classified on its own into `status_hi`, `fix_byte_hi` and `fix_mask_hi`. `status` is the numerically larger of `status_lo` and `status_hi`.
- R8: With `wide_page` = 0, bits [47:24] have no effect. `status_hi` is 2'b00, `fix_byte_hi` and `fix_mask_hi` are zero, and `status` equals `status_lo`.
- R9: While `rst_n` is low, `done` is 0, all three status outputs are 2'b00, and all offsets and masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: code inputs are valid this cycle |
| wide_page | input | 1 | 1 = 512-byte page (two chunks), 0 = 256-byte page |
| calc_code | input | 48 | Computed codes, byte 0 in bits [7:0]; upper chunk in [47:24] |
| stored_code | input | 48 | Codes read back from the spare area, same packing |
| done | output | 1 | One-cycle pulse: results are fresh |
| status | output | 2 | Worst class over the page |
| status_lo | output | 2 | Class of the lower chunk |
| status_hi | output | 2 | Class of the upper chunk |
| fix_byte_lo | output | 8 | Failing byte offset in the lower chunk |
| fix_mask_lo | output | 8 | One-hot bit to flip in that byte |
| fix_byte_hi | output | 8 | Failing byte offset in the upper chunk |
| fix_mask_hi | output | 8 | One-hot bit to flip in that byte |

## Verification
A wrong phase state would show as a `done` pulse missing, doubled or late by a cycle, visible on the cycle after the strobe. A wrong result register would show as a class or mask changing without a strobe, caught on the cycle after the stray update. Misclassification or a shifted locator field shows at the status and mask ports on the very cycle `done` rises. The sweeps over every one of the 2048 bit locations, every single-bit syndrome and every syndrome pair expose such faults on the first affected pattern.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    // Per-chunk verdict; numeric order is severity order.
    typedef enum logic [1:0] {
        CK_CLEAN    = 2'b00,
        CK_FIXABLE  = 2'b01,
        CK_CODE_BAD = 2'b10,
        CK_LOST     = 2'b11
    } chunk_status_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_REPORT = 1'b1
    } phase_e;

    function automatic chunk_status_e worse_of(chunk_status_e a, chunk_status_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W     = 24,
    parameter int GRP   = 4,
    localparam int CNT_W = $clog2(W + 1),
    localparam int NGRP  = (W + GRP - 1) / GRP,
    localparam int GCW   = $clog2(GRP + 1)
) (
    input  logic [W-1:0]     bits_in,
    output logic [CNT_W-1:0] count
);

    logic [GCW-1:0] grp_cnt [NGRP];

    // first tree level: small per-group counts
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            grp_cnt[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                if (g * GRP + b < W) begin
                    grp_cnt[g] = grp_cnt[g] + GCW'(bits_in[g * GRP + b]);
                end
            end
        end
    end

    // second level: sum of group counts
    always_comb begin
        count = '0;
        for (int g = 0; g < NGRP; g++) begin
            count = count + CNT_W'(grp_cnt[g]);
        end
    end

endmodule

// File: rtl/ecc_chunk_classify.sv
module ecc_chunk_classify
    import nand_ecc_pkg::*;
#(
    parameter int CODE_W = 24,
    parameter int GRP_W  = 11,
    localparam int BIT_W  = 3,
    localparam int BYTE_W = GRP_W - BIT_W,
    localparam int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0]   calc,
    input  logic [CODE_W-1:0]   stored,
    output chunk_status_e       verdict,
    output logic [BYTE_W-1:0]   byte_idx,
    output logic [(1<<BIT_W)-1:0] bit_mask
);

    logic [CODE_W-1:0] syn;
    logic [CNT_W-1:0]  weight;
    logic [GRP_W-1:0]  fold_calc, fold_stored, fold_pair;

    assign syn = calc ^ stored;

    ecc_popcount #(.W(CODE_W)) u_pop (
        .bits_in (syn),
        .count   (weight)
    );

    assign fold_calc   = calc[GRP_W-1:0]   ^ calc[2*GRP_W-1:GRP_W];
    assign fold_stored = stored[GRP_W-1:0] ^ stored[2*GRP_W-1:GRP_W];
    assign fold_pair   = fold_calc ^ fold_stored;

    always_comb begin
        byte_idx = '0;
        bit_mask = '0;
        if (syn == '0 || calc == '0 || stored == '0) begin
            verdict = CK_CLEAN;
        end else if (weight == CNT_W'(1)) begin
            verdict = CK_CODE_BAD;
        end else if (weight == CNT_W'(GRP_W) && fold_pair == {GRP_W{1'b1}}) begin
            verdict  = CK_FIXABLE;
            byte_idx = syn[GRP_W-1:BIT_W];
            bit_mask = (1 << BIT_W)'(1) << syn[BIT_W-1:0];
        end else begin
            verdict = CK_LOST;
        end
    end

endmodule

// File: rtl/nand_ecc_syndrome.sv
module nand_ecc_syndrome
    import nand_ecc_pkg::*;
#(
    parameter int CODE_W = 24,
    parameter int GRP_W  = 11,
    localparam int NCHUNK = 2,
    localparam int BYTE_W = GRP_W - 3,
    localparam int IN_W   = NCHUNK * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wide_page,
    input  logic [IN_W-1:0]   calc_code,
    input  logic [IN_W-1:0]   stored_code,
    output logic              done,
    output logic [1:0]        status,
    output logic [1:0]        status_lo,
    output logic [1:0]        status_hi,
    output logic [BYTE_W-1:0] fix_byte_lo,
    output logic [7:0]        fix_mask_lo,
    output logic [BYTE_W-1:0] fix_byte_hi,
    output logic [7:0]        fix_mask_hi
);

    chunk_status_e     raw_st   [NCHUNK];
    logic [BYTE_W-1:0] raw_byte [NCHUNK];
    logic [7:0]        raw_mask [NCHUNK];
    chunk_status_e     use_st   [NCHUNK];
    logic [BYTE_W-1:0] use_byte [NCHUNK];
    logic [7:0]        use_mask [NCHUNK];

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        ecc_chunk_classify #(.CODE_W(CODE_W), .GRP_W(GRP_W)) u_cls (
            .calc     (calc_code[c*CODE_W +: CODE_W]),
            .stored   (stored_code[c*CODE_W +: CODE_W]),
            .verdict  (raw_st[c]),
            .byte_idx (raw_byte[c]),
            .bit_mask (raw_mask[c])
        );
        // upper chunk only counts in the wide page mode
        if (c == 0) begin : g_always
            assign use_st[c]   = raw_st[c];
            assign use_byte[c] = raw_byte[c];
            assign use_mask[c] = raw_mask[c];
        end else begin : g_gated
            assign use_st[c]   = wide_page ? raw_st[c] : CK_CLEAN;
            assign use_byte[c] = wide_page ? raw_byte[c] : '0;
            assign use_mask[c] = wide_page ? raw_mask[c] : '0;
        end
    end

    phase_e phase, phase_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // transitions: take / retire
    always_comb begin
        unique case (phase)
            PH_IDLE:   phase_nx = in_valid ? PH_REPORT : PH_IDLE;
            PH_REPORT: phase_nx = in_valid ? PH_REPORT : PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // output process: capture verdicts on the take transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status      <= CK_CLEAN;
            status_lo   <= CK_CLEAN;
            status_hi   <= CK_CLEAN;
            fix_byte_lo <= '0;
            fix_mask_lo <= '0;
            fix_byte_hi <= '0;
            fix_mask_hi <= '0;
        end else if (phase_nx == PH_REPORT) begin
            status      <= worse_of(use_st[0], use_st[1]);
            status_lo   <= use_st[0];
            status_hi   <= use_st[1];
            fix_byte_lo <= use_byte[0];
            fix_mask_lo <= use_mask[0];
            fix_byte_hi <= use_byte[1];
            fix_mask_hi <= use_mask[1];
        end
    end

    assign done = (phase == PH_REPORT);

endmodule

// File: rtl/nand_ecc_syndrome_chk.sv
module nand_ecc_syndrome_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              wide_page,
    input logic              done,
    input logic [1:0]        status,
    input logic [1:0]        status_lo,
    input logic [1:0]        status_hi,
    input logic [BYTE_W-1:0] fix_byte_lo,
    input logic [7:0]        fix_mask_lo,
    input logic [BYTE_W-1:0] fix_byte_hi,
    input logic [7:0]        fix_mask_hi
);

    assert_done_after_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(status) && $stable(status_lo) && $stable(status_hi)
                      && $stable(fix_mask_lo) && $stable(fix_mask_hi)));

    assert_mask_quiet_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_lo != 2'b01) |-> (fix_mask_lo == 8'd0 && fix_byte_lo == '0));

    assert_mask_quiet_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_hi != 2'b01) |-> (fix_mask_hi == 8'd0 && fix_byte_hi == '0));

    assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_lo == 2'b01) |-> ($countones(fix_mask_lo) == 1));

    assert_worst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status >= status_lo && status >= status_hi
                  && (status == status_lo || status == status_hi)));

    assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_page) |=> (status_hi == 2'b00 && fix_mask_hi == 8'd0));

endmodule

bind nand_ecc_syndrome nand_ecc_syndrome_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .wide_page   (wide_page),
    .done        (done),
    .status      (status),
    .status_lo   (status_lo),
    .status_hi   (status_hi),
    .fix_byte_lo (fix_byte_lo),
    .fix_mask_lo (fix_mask_lo),
    .fix_byte_hi (fix_byte_hi),
    .fix_mask_hi (fix_mask_hi)
);

// File: tb/nand_ecc_syndrome_tb.sv
module nand_ecc_syndrome_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] BASE = 24'h5A3C96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        wide_page = 1'b0;
    logic [47:0] calc_code = '0;
    logic [47:0] stored_code = '0;
    logic        done;
    logic [1:0]  status, status_lo, status_hi;
    logic [7:0]  fix_byte_lo, fix_mask_lo, fix_byte_hi, fix_mask_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_ecc_syndrome u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_page(wide_page),
        .calc_code(calc_code), .stored_code(stored_code), .done(done),
        .status(status), .status_lo(status_lo), .status_hi(status_hi),
        .fix_byte_lo(fix_byte_lo), .fix_mask_lo(fix_mask_lo),
        .fix_byte_hi(fix_byte_hi), .fix_mask_hi(fix_mask_hi)
    );

    function automatic logic [23:0] data_err(input logic [10:0] loc);
        return {2'b00, ~loc, loc};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // drive one strobe, sample the registered result on the next negedge
    task automatic run(input string req, input logic wide,
                       input logic [47:0] c, input logic [47:0] s,
                       input logic [1:0] e_lo, input logic [7:0] e_blo, input logic [7:0] e_mlo,
                       input logic [1:0] e_hi, input logic [7:0] e_bhi, input logic [7:0] e_mhi);
        logic [1:0] e_all;
        e_all = (e_lo > e_hi) ? e_lo : e_hi;
        @(negedge clk);
        wide_page = wide; calc_code = c; stored_code = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req,
              {25'd0, done, status, status_lo, status_hi, fix_byte_lo, fix_mask_lo, fix_byte_hi, fix_mask_hi},
              {25'd0, 1'b1, e_all, e_lo, e_hi, e_blo, e_mlo, e_bhi, e_mhi});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog got=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {49'd0, done, status, status_lo, status_hi, fix_mask_lo, fix_mask_hi}, 64'd0);
        rst_n = 1'b1;

        // R1: clean cases
        run("R1 equal", 1'b0, {24'd0, BASE}, {24'd0, BASE}, 2'b00, 0, 0, 2'b00, 0, 0);
        run("R1 calc zero", 1'b0, 48'd0, {24'd0, BASE}, 2'b00, 0, 0, 2'b00, 0, 0);
        run("R1 stored zero", 1'b0, {24'd0, BASE ^ 24'h000FF0}, 48'd0, 2'b00, 0, 0, 2'b00, 0, 0);

        // R6: done drops, results hold
        @(negedge clk);
        check("R6 done drop", {63'd0, done}, 64'd0);
        run("R6 load", 1'b0, {24'd0, BASE ^ 24'h000003}, {24'd0, BASE}, 2'b11, 0, 0, 2'b00, 0, 0);
        held = status;
        @(negedge clk); @(negedge clk);
        check("R6 hold", {61'd0, done, held}, {61'd0, 1'b0, 2'b11});

        // R2: every single syndrome bit
        for (int k = 0; k < 24; k++) begin
            run("R2", 1'b0, {24'd0, BASE ^ (24'd1 << k)}, {24'd0, BASE}, 2'b10, 0, 0, 2'b00, 0, 0);
        end

        // R3/R5: every data-bit location in the lower chunk
        for (int l = 0; l < 2048; l++) begin
            run("R3 lo", 1'b0, {24'd0, BASE ^ data_err(11'(l))}, {24'd0, BASE},
                2'b01, 8'(l >> 3), 8'd1 << (l % 8), 2'b00, 0, 0);
        end

        // R7: upper chunk sweep, lower chunk with a code error (worse wins)
        for (int l = 0; l < 2048; l++) begin
            run("R7 hi", 1'b1, {BASE ^ data_err(11'(l)), BASE ^ (24'd1 << (l % 24))}, {BASE, BASE},
                2'b10, 0, 0, 2'b01, 8'(l >> 3), 8'd1 << (l % 8));
        end
        run("R7 lost lo", 1'b1, {BASE, BASE ^ 24'h000300}, {BASE, BASE}, 2'b11, 0, 0, 2'b00, 0, 0);
        run("R7 two fixes", 1'b1, {BASE ^ data_err(11'd2047), BASE ^ data_err(11'd5)}, {BASE, BASE},
            2'b01, 8'd0, 8'h20, 2'b01, 8'd255, 8'h80);

        // R4: every syndrome pair, a triple, and 11 bits that are not complementary
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                run("R4 pair", 1'b0, {24'd0, BASE ^ (24'd1 << i) ^ (24'd1 << j)}, {24'd0, BASE},
                    2'b11, 0, 0, 2'b00, 0, 0);
            end
        end
        run("R4 triple", 1'b0, {24'd0, BASE ^ 24'h800101}, {24'd0, BASE}, 2'b11, 0, 0, 2'b00, 0, 0);
        run("R4 not complementary", 1'b0, {24'd0, BASE ^ 24'h4007FE}, {24'd0, BASE},
            2'b11, 0, 0, 2'b00, 0, 0);

        // R8: upper half ignored in narrow mode
        run("R8 ignore hi", 1'b0, {BASE ^ 24'h000003, BASE ^ data_err(11'd9)}, {BASE, BASE},
            2'b01, 8'd1, 8'h02, 2'b00, 0, 0);
        run("R8 ignore hi2", 1'b0, {BASE ^ data_err(11'd100), BASE}, {BASE, BASE},
            2'b00, 0, 0, 2'b00, 0, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule